// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Selector

This block holds replacement history for an 8-way set-associative cache. It keeps a 7-bit binary decision tree for every set. On a miss it names the way to refill. The tree has a root bit, two middle bits and four leaf bits. Reading the tree from the root down picks one of the eight ways. Each access to a way writes three fixed bits on that way's path, so the tree then points away from the way just used.

Empty ways are filled before any line is evicted. While the set's valid mask has a zero, the victim is the lowest-numbered invalid way and the tree is not consulted. A flag shows which of the two rules chose the victim. The number of sets is a parameter. The per-set state array lives inside the block. Tags, data and refill are handled elsewhere.

Top module: `plru8_victim_sel`

## Requirements
- R1: A synchronous reset clears every tree bit of every set. After reset, a query with a full valid mask returns way 0 for any set.
- R2: With a full valid mask, root bit b0 (tree bit 0) picks the half. b0=1 selects ways 4..7 and middle bit b2 (tree bit 2). b0=0 selects ways 0..3 and middle bit b1 (tree bit 1).
- R3: Leaf selection with a full mask. Upper half with b2=1: b6 (bit 6) gives way 7 if 1, way 6 if 0. Upper half with b2=0: b5 gives way 5 if 1, way 4 if 0. Lower half with b1=1: b4 gives way 3 if 1, way 2 if 0. Lower half with b1=0: b3 gives way 1 if 1, way 0 if 0.
- R4: While the valid mask (bit n = way n) is not all ones, the victim is the lowest-index way whose valid bit is 0 and `vic_from_free` is 1. The tree has no effect on this choice.
- R5: With a full valid mask, `vic_from_free` is 0 and the victim comes from the tree walk.
- R6: An access to ways 0 to 3 writes these bits:
  - way 0: b0=1, b1=1, b3=1
  - way 1: b0=1, b1=1, b3=0
  - way 2: b0=1, b1=0, b4=1
  - way 3: b0=1, b1=0, b4=0
- R7: An access to ways 4 to 7 writes these bits:
  - way 4: b0=0, b2=1, b5=1
  - way 5: b0=0, b2=1, b5=0
  - way 6: b0=0, b2=0, b6=1
  - way 7: b0=0, b2=0, b6=0
- R8: An access changes only the three bits of its way in the addressed set. Every other bit of that set, and the trees of all other sets, keep their values.
- R9: The victim is combinational from the stored tree of `set_idx`. An access in the same cycle takes effect at the clock edge, so a query in that cycle sees the tree as it was before the update.
- R10: While `vic_req` is 0, `vic_way` and `vic_from_free` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | SET_W | Set addressed by both the query and the access |
| valid_mask | input | 8 | Valid bits of the addressed set, bit n = way n |
| acc_en | input | 1 | Access strobe; updates the tree at the clock edge |
| acc_way | input | 3 | Way that was accessed |
| vic_req | input | 1 | Victim query |
| vic_way | output | 3 | Chosen victim way |
| vic_from_free | output | 1 | 1 when the victim came from the invalid-way search |

## Verification
The assertions take `set_idx`, `acc_way` and `valid_mask` to be known (not X) whenever they are sampled outside reset. They also take `set_idx` to be below NUM_SETS, because a larger index would read and write nothing. The bench drives every input from the first edge on and uses only in-range set numbers. It sweeps valid masks exhaustively and walks the trees through long pseudo-random access sequences, all with a small set count so every set is revisited often.

// File: rtl/plru8_pkg.sv
package plru8_pkg;
   localparam int WAYS   = 8;
   localparam int TREE_W = WAYS - 1;

   typedef logic [2:0]        way_t;
   typedef logic [TREE_W-1:0] tree_t;

   // Bits written by an access to way w: the root, the middle node of
   // its half, and the leaf of its pair.
   function automatic tree_t touch_mask(way_t w);
      tree_t m;
      m = '0;
      m[0] = 1'b1;
      m[w[2] ? 2 : 1] = 1'b1;
      m[3 + int'(w[2:1])] = 1'b1;
      return m;
   endfunction

   // Values written on those bits: each one points away from w.
   function automatic tree_t touch_value(way_t w);
      tree_t v;
      v = '0;
      v[0] = ~w[2];
      v[w[2] ? 2 : 1] = ~w[1];
      v[3 + int'(w[2:1])] = ~w[0];
      return v;
   endfunction
endpackage

// File: rtl/plru8_tree_store.sv
module plru8_tree_store
   import plru8_pkg::*;
#(
   parameter int NUM_SETS = 128,
   localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_idx,
   input  logic             wr_en,
   input  way_t             wr_way,
   output tree_t            rd_tree
);
   tree_t tree_q [NUM_SETS];
   tree_t upd_mask, upd_val, next_tree;

   assign rd_tree   = tree_q[set_idx];
   assign upd_mask  = touch_mask(wr_way);
   assign upd_val   = touch_value(wr_way);
   assign next_tree = (rd_tree & ~upd_mask) | (upd_val & upd_mask);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
      end else if (wr_en) begin
         tree_q[set_idx] <= next_tree;
      end
   end

   // R1: reset leaves the addressed tree cleared
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> (rd_tree == '0));

   // R6: lower-half ways write their path bits
   p_touch_low_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_way[2]) |=>
         (tree_q[$past(set_idx)][0] == 1'b1) &&
         (tree_q[$past(set_idx)][1] == !$past(wr_way[1])) &&
         (tree_q[$past(set_idx)][3 + int'($past(wr_way[1]))] == !$past(wr_way[0])));

   // R7: upper-half ways write their path bits
   p_touch_high_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_way[2]) |=>
         (tree_q[$past(set_idx)][0] == 1'b0) &&
         (tree_q[$past(set_idx)][2] == !$past(wr_way[1])) &&
         (tree_q[$past(set_idx)][5 + int'($past(wr_way[1]))] == !$past(wr_way[0])));

   // R8: bits off the accessed way's path keep their value
   p_keep_rest_r8: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ((tree_q[$past(set_idx)] & ~$past(upd_mask)) ==
                 ($past(rd_tree) & ~$past(upd_mask))));
endmodule

// File: rtl/plru8_tree_walk.sv
module plru8_tree_walk
   import plru8_pkg::*;
(
   input  tree_t tree,
   output way_t  way
);
   logic half, mid, leaf;

   always_comb begin
      half = tree[0];
      mid  = half ? tree[2] : tree[1];
      leaf = tree[3 + int'({half, mid})];
      way  = {half, mid, leaf};
   end
endmodule

// File: rtl/plru8_free_pick.sv
module plru8_free_pick
   import plru8_pkg::*;
(
   input  logic [WAYS-1:0] valid,
   output way_t            way,
   output logic            any_free
);
   logic [WAYS:0]   lower_full;
   logic [WAYS-1:0] first_free;

   assign lower_full[0] = 1'b1;

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_chain
         assign lower_full[w+1] = lower_full[w] & valid[w];
         assign first_free[w]   = lower_full[w] & ~valid[w];
      end
   endgenerate

   assign any_free = ~lower_full[WAYS];

   always_comb begin
      way = '0;
      for (int i = 0; i < WAYS; i++)
         if (first_free[i]) way = way | way_t'(i);
   end
endmodule

// File: rtl/plru8_victim_sel.sv
module plru8_victim_sel
   import plru8_pkg::*;
#(
   parameter int NUM_SETS = 128,
   localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SET_W-1:0] set_idx,
   input  logic [7:0]       valid_mask,
   input  logic             acc_en,
   input  logic [2:0]       acc_way,
   input  logic             vic_req,
   output logic [2:0]       vic_way,
   output logic             vic_from_free
);
   generate
      if (NUM_SETS < 2) begin : g_bad_sets
         $error("plru8_victim_sel: NUM_SETS must be at least 2");
      end
   endgenerate

   tree_t cur_tree;
   way_t  tree_way, free_way;
   logic  has_free;

   plru8_tree_store #(.NUM_SETS(NUM_SETS)) u_store (
      .clk     (clk),
      .rst     (rst),
      .set_idx (set_idx),
      .wr_en   (acc_en),
      .wr_way  (acc_way),
      .rd_tree (cur_tree)
   );

   plru8_tree_walk u_walk (
      .tree (cur_tree),
      .way  (tree_way)
   );

   plru8_free_pick u_free (
      .valid    (valid_mask),
      .way      (free_way),
      .any_free (has_free)
   );

   always_comb begin
      vic_way       = '0;
      vic_from_free = 1'b0;
      if (vic_req) begin
         vic_from_free = has_free;
         vic_way       = has_free ? free_way : tree_way;
      end
   end

   // R2: root bit selects the half
   p_root_half_r2: assert property (@(posedge clk) disable iff (rst)
      (vic_req && &valid_mask) |-> (vic_way[2] == cur_tree[0]));

   // R3: upper half, middle bit set, leaf b6 decides
   p_leaf_b6_r3: assert property (@(posedge clk) disable iff (rst)
      (vic_req && &valid_mask && cur_tree[0] && cur_tree[2]) |->
         (vic_way == {2'b11, cur_tree[6]}));

   // R4: lowest invalid way wins while any way is empty
   p_free_lowest_r4: assert property (@(posedge clk) disable iff (rst)
      (vic_req && !(&valid_mask)) |->
         (vic_from_free && !valid_mask[vic_way] &&
          ((valid_mask & ((8'd1 << vic_way) - 8'd1)) == ((8'd1 << vic_way) - 8'd1))));

   // R5: a full set takes the tree
   p_full_tree_r5: assert property (@(posedge clk) disable iff (rst)
      (vic_req && &valid_mask) |-> !vic_from_free);

   // R10: no query, quiet outputs
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
      !vic_req |-> (vic_way == 3'd0 && !vic_from_free));
endmodule

// File: tb/plru8_victim_sel_tb.sv
module plru8_victim_sel_tb;
   localparam int NS = 4;
   localparam int SW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [SW-1:0] set_idx = '0;
   logic [7:0]    valid_mask = 8'hFF;
   logic          acc_en = 1'b0;
   logic [2:0]    acc_way = '0;
   logic          vic_req = 1'b0;
   logic [2:0]    vic_way;
   logic          vic_from_free;

   int checks = 0;
   int errors = 0;
   logic [6:0] m_tree [NS];
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   plru8_victim_sel #(.NUM_SETS(NS)) u_dut (
      .clk, .rst, .set_idx, .valid_mask, .acc_en, .acc_way, .vic_req,
      .vic_way, .vic_from_free
   );

   function automatic logic [2:0] exp_walk(logic [6:0] t);
      if (t[0]) begin
         if (t[2]) return t[6] ? 3'd7 : 3'd6;
         else      return t[5] ? 3'd5 : 3'd4;
      end else begin
         if (t[1]) return t[4] ? 3'd3 : 3'd2;
         else      return t[3] ? 3'd1 : 3'd0;
      end
   endfunction

   function automatic logic [6:0] exp_touch(logic [6:0] t, logic [2:0] w);
      logic [6:0] r;
      r = t;
      case (w)
         3'd0: begin r[0] = 1; r[1] = 1; r[3] = 1; end
         3'd1: begin r[0] = 1; r[1] = 1; r[3] = 0; end
         3'd2: begin r[0] = 1; r[1] = 0; r[4] = 1; end
         3'd3: begin r[0] = 1; r[1] = 0; r[4] = 0; end
         3'd4: begin r[0] = 0; r[2] = 1; r[5] = 1; end
         3'd5: begin r[0] = 0; r[2] = 1; r[5] = 0; end
         3'd6: begin r[0] = 0; r[2] = 0; r[6] = 1; end
         default: begin r[0] = 0; r[2] = 0; r[6] = 0; end
      endcase
      return r;
   endfunction

   task automatic check(string req, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   // Query a set with full mask: {from_free, way}
   task automatic probe_full(int s, string req);
      @(negedge clk);
      acc_en = 0; vic_req = 1; valid_mask = 8'hFF; set_idx = SW'(s);
      #1 check(req, {vic_from_free, vic_way}, {1'b0, exp_walk(m_tree[s])});
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;
      for (int s = 0; s < NS; s++) m_tree[s] = '0;

      // R1: reset state
      for (int s = 0; s < NS; s++) probe_full(s, "R1");

      // R4: exhaustive masks with a non-zero tree
      @(negedge clk); set_idx = 1; acc_en = 1; acc_way = 3'd0; vic_req = 0;
      #1 check("R10", {vic_from_free, vic_way}, 4'h0);
      @(posedge clk); m_tree[1] = exp_touch(m_tree[1], 3'd0);
      for (int m = 0; m < 255; m++) begin
         int low;
         @(negedge clk);
         acc_en = 0; vic_req = 1; set_idx = 1; valid_mask = 8'(m);
         low = 0;
         while (m[low]) low++;
         #1 check("R4", {vic_from_free, vic_way}, {1'b1, 3'(low)});
      end

      // R6 R7: each way from a cleared set, then probe
      for (int w = 0; w < 8; w++) begin
         @(negedge clk); rst = 1; acc_en = 0;
         @(negedge clk); rst = 0;
         for (int s = 0; s < NS; s++) m_tree[s] = '0;
         @(negedge clk); set_idx = 2; acc_en = 1; acc_way = 3'(w); vic_req = 1;
         valid_mask = 8'hFF;
         #1 check("R9", {vic_from_free, vic_way}, {1'b0, exp_walk(m_tree[2])});
         @(posedge clk); m_tree[2] = exp_touch(m_tree[2], 3'(w));
         probe_full(2, (w < 4) ? "R6" : "R7");
         probe_full(0, "R8");
      end

      // R2 R3 R5 R8 R9: long pseudo-random access walk
      for (int n = 0; n < 1500; n++) begin
         int s;
         logic [2:0] w;
         step_lfsr();
         s = int'(lfsr[1:0]);
         w = lfsr[6:4];
         @(negedge clk);
         set_idx = SW'(s); acc_en = 1; acc_way = w; vic_req = 1; valid_mask = 8'hFF;
         #1 check("R9", {vic_from_free, vic_way}, {1'b0, exp_walk(m_tree[s])});
         @(posedge clk); m_tree[s] = exp_touch(m_tree[s], w);
         if (n % 8 == 0)
            for (int q = 0; q < NS; q++) probe_full(q, "R8");
         else
            probe_full(s, "R2 R3 R5");
      end

      // R10: idle outputs with a free way present
      @(negedge clk); acc_en = 0; vic_req = 0; valid_mask = 8'h0F;
      #1 check("R10", {vic_from_free, vic_way}, 4'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule